// File: doc/BRIEF.md
# Serial Gamepad Responder

This block stands in for the controller end of a three-wire gamepad link. The host drives a latch line and a data clock, and the block answers on a single serial data line. Local logic supplies a 12-bit vector of button states, where a 1 means the button is pressed. The block runs in a fast system clock. It passes the host's latch and clock through synchronisers and detects their edges in that domain.

A high latch loads a snapshot of the button vector into a 16-slot shift register, with slot 0 presented at once. Each rising edge of the host clock moves the register on by one slot, so the host can sample a settled bit on every falling edge. Slots 0 to 11 carry the buttons in the order B, Y, Select, Start, Up, Down, Left, Right, A, X, L, R, which is `buttons_pressed[0]` to `buttons_pressed[11]`. Slots 12 to 15 are padding. The wire is active-low.

The frame state machine has four states:
- `ST_IDLE`: reached by reset; no frame has been latched yet and the line rests at 1.
- `ST_LOAD`: entered from any state while the synchronised latch is high; the snapshot is reloaded on every cycle.
- `ST_SHIFT`: entered from `ST_LOAD` when the latch falls; it advances one slot per host clock rise.
- `ST_DONE`: entered from `ST_SHIFT` on the rise that ends slot 15; the line holds 1 until the next latch.

Top module: `pad_responder`

## Requirements
- R1: While reset is asserted and after it is released, before any latch, `ser_data` is 1.
- R2: Three system cycles after `host_latch` goes high, `ser_data` shows slot 0, which is the inverse of `buttons_pressed[0]`, and holds it while the latch stays high.
- R3: Each rising edge of `host_clk` after the latch has fallen advances the output by exactly one slot, visible three system cycles after the edge.
- R4: Slot i, for i from 0 to 11, carries `buttons_pressed[i]`, giving the wire order B, Y, Select, Start, Up, Down, Left, Right, A, X, L, R.
- R5: Data is active-low: a pressed button (input bit 1) drives 0 and a released button (input bit 0) drives 1.
- R6: Slots 12 to 15 always drive 1.
- R7: After the 16th rising clock edge of a frame, `ser_data` stays 1 and further clock edges are ignored until the next latch.
- R8: A latch pulse in the middle of a frame restarts it from slot 0 with a fresh snapshot.
- R9: Changes to `buttons_pressed` after the latch has fallen do not alter the frame being sent.
- R10: Falling edges of `host_clk` do not change `ser_data`; the bit stays stable through the low phase up to the next rising edge.
- R11: The latch and clock inputs pass through two synchroniser flops, so a clock rise has not yet changed `ser_data` two system cycles after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_latch | input | 1 | Latch line from the host, high starts a frame |
| host_clk | input | 1 | Data clock from the host, idles high |
| buttons_pressed | input | 12 | Button states, 1 = pressed, bit 0 = B through bit 11 = R |
| ser_data | output | 1 | Serial data line to the host, active-low |

## Verification
The bench builds the block with its default parameters: 12 buttons, 16 frame slots and two synchroniser stages. With these values all four padding slots, the saturation of the slot counter after the last slot and the full three-cycle input latency can be seen at the ports. A behavioural reference model is compared on every system clock, across frames of different patterns, a restart in mid-frame, button changes during a frame and extra clock pulses after a frame.

// File: rtl/pad_pkg.sv
package pad_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } frame_state_e;

endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
    parameter int WIDTH   = 2,
    parameter int STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= RST_VAL;
                end else if (g == 0) begin
                    chain[g] <= async_in;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/pad_frame.sv
module pad_frame
    import pad_pkg::*;
#(
    parameter int NUM_BUTTONS = 12,
    parameter int FRAME_SLOTS = 16,
    localparam int PAD_SLOTS  = FRAME_SLOTS - NUM_BUTTONS,
    localparam int CNT_W      = $clog2(FRAME_SLOTS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lat_sync,
    input  logic                   clk_sync,
    input  logic [NUM_BUTTONS-1:0] buttons_pressed,
    output logic                   ser_data,
    output frame_state_e           state,
    output logic [CNT_W-1:0]       slot_cnt
);

    frame_state_e           state_nxt;
    logic                   clk_prev;
    logic                   clk_rise;
    logic [FRAME_SLOTS-1:0] shreg;
    logic [FRAME_SLOTS-1:0] load_img;

    // Snapshot image: padding ones on top, inverted buttons below (slot 0 = bit 0).
    assign load_img = {{PAD_SLOTS{1'b1}}, ~buttons_pressed};

    // Host clock idles high, so the edge register also resets high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_prev <= 1'b1;
        else        clk_prev <= clk_sync;
    end

    assign clk_rise = clk_sync & ~clk_prev;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        if (lat_sync) begin
            state_nxt = ST_LOAD;
        end else begin
            unique case (state)
                ST_IDLE:  state_nxt = ST_IDLE;
                ST_LOAD:  state_nxt = ST_SHIFT;
                ST_SHIFT: begin
                    if (clk_rise && (slot_cnt == CNT_W'(FRAME_SLOTS - 1)))
                        state_nxt = ST_DONE;
                end
                ST_DONE:  state_nxt = ST_DONE;
                default:  state_nxt = ST_IDLE;
            endcase
        end
    end

    // Output datapath: shift register and slot counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '1;
            slot_cnt <= '0;
        end else if (lat_sync) begin
            shreg    <= load_img;
            slot_cnt <= '0;
        end else begin
            unique case (state)
                ST_SHIFT: begin
                    if (clk_rise) begin
                        shreg    <= {1'b1, shreg[FRAME_SLOTS-1:1]};
                        slot_cnt <= slot_cnt + 1'b1;
                    end
                end
                ST_DONE:  shreg <= '1;
                default:  ;
            endcase
        end
    end

    assign ser_data = shreg[0];

endmodule

// File: rtl/pad_responder.sv
module pad_responder
    import pad_pkg::*;
#(
    parameter int NUM_BUTTONS = 12,
    parameter int FRAME_SLOTS = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(FRAME_SLOTS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_latch,
    input  logic                   host_clk,
    input  logic [NUM_BUTTONS-1:0] buttons_pressed,
    output logic                   ser_data
);

    logic             lat_sync;
    logic             clk_sync;
    frame_state_e     frame_state;
    logic [CNT_W-1:0] slot_cnt;

    // bit 1 = latch (rests low), bit 0 = clock (rests high)
    pad_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b01)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({host_latch, host_clk}),
        .sync_out ({lat_sync, clk_sync})
    );

    pad_frame #(
        .NUM_BUTTONS (NUM_BUTTONS),
        .FRAME_SLOTS (FRAME_SLOTS)
    ) u_frame (
        .clk             (clk),
        .rst_n           (rst_n),
        .lat_sync        (lat_sync),
        .clk_sync        (clk_sync),
        .buttons_pressed (buttons_pressed),
        .ser_data        (ser_data),
        .state           (frame_state),
        .slot_cnt        (slot_cnt)
    );

endmodule

// File: rtl/pad_responder_chk.sv
module pad_responder_chk
    import pad_pkg::*;
#(
    parameter int NUM_BUTTONS = 12,
    parameter int FRAME_SLOTS = 16,
    localparam int CNT_W      = $clog2(FRAME_SLOTS + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lat_sync,
    input logic                   clk_sync,
    input logic [NUM_BUTTONS-1:0] buttons_pressed,
    input logic                   ser_data,
    input frame_state_e           frame_state,
    input logic [CNT_W-1:0]       slot_cnt
);

    // R1: reset drives the line to released
    a_r1_reset_high: assert property (@(posedge clk)
        !rst_n |=> ser_data);

    // R2: a synchronised latch presents the inverse of button 0
    a_r2_load_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        lat_sync |=> (ser_data == !$past(buttons_pressed[0])));

    // R10: without latch or clock rise the line holds its value
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat_sync && !(clk_sync && !$past(clk_sync))) |=> $stable(ser_data));

    // R6: padding slots read as 1
    a_r6_pad_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((frame_state == ST_SHIFT) && (slot_cnt >= CNT_W'(NUM_BUTTONS))) |-> ser_data);

    // R7: a finished frame keeps the line at 1
    a_r7_done_high: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_state == ST_DONE) |-> ser_data);

    // R3: the slot counter never runs past the frame length
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        slot_cnt <= CNT_W'(FRAME_SLOTS));

endmodule

bind pad_responder pad_responder_chk #(
    .NUM_BUTTONS (NUM_BUTTONS),
    .FRAME_SLOTS (FRAME_SLOTS)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .lat_sync        (lat_sync),
    .clk_sync        (clk_sync),
    .buttons_pressed (buttons_pressed),
    .ser_data        (ser_data),
    .frame_state     (frame_state),
    .slot_cnt        (slot_cnt)
);

// File: tb/pad_responder_tb.sv
module pad_responder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 12;
    localparam int NS         = 16;
    localparam int HALF       = 8;
    localparam int WATCHDOG   = 50000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_latch = 1'b0;
    logic          host_clk = 1'b1;
    logic [NB-1:0] buttons_pressed = '0;
    logic          ser_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pad_responder u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .host_latch      (host_latch),
        .host_clk        (host_clk),
        .buttons_pressed (buttons_pressed),
        .ser_data        (ser_data)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic slot_bit(input logic [NB-1:0] p, input int s);
        return (s < NB) ? !p[s] : 1'b1;
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- reference model, compared every clock ----------------
    int            m_slot = -1;
    logic [NB-1:0] m_snap = '0;
    logic          m1_lat = 0, m2_lat = 0;
    logic          m1_clk = 1, m2_clk = 1, mq_clk = 1;
    logic          m_exp;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_slot = -1;
            m1_lat = 0; m2_lat = 0;
            m1_clk = 1; m2_clk = 1; mq_clk = 1;
        end else begin
            if (m2_lat) begin
                m_slot = 0;
                m_snap = buttons_pressed;
            end else if (m2_clk && !mq_clk && m_slot >= 0 && m_slot < NS) begin
                m_slot = m_slot + 1;
            end
            mq_clk = m2_clk;
            m2_lat = m1_lat; m2_clk = m1_clk;
            m1_lat = host_latch; m1_clk = host_clk;
        end
    end

    always_comb m_exp = (m_slot >= 0 && m_slot < NB) ? !m_snap[m_slot] : 1'b1;

    always @(negedge clk) begin
        if (rst_n && !done) chk("R3 model", ser_data, m_exp);
    end

    // ---------------- directed frames ----------------
    task automatic latch_frame(input logic [NB-1:0] pat, input string tag);
        buttons_pressed = pat;
        host_latch = 1'b1;
        wait_n(6);
        chk(tag, ser_data, !pat[0]);            // R2 / R8
        wait_n(6);
        host_latch = 1'b0;
        wait_n(6);
    endtask

    task automatic clock_slots(input logic [NB-1:0] pat, input int nslots, input bit scramble);
        for (int s = 0; s < nslots; s++) begin
            chk((s < NB) ? "R4 R5 slot" : "R6 pad slot", ser_data, slot_bit(pat, s));
            host_clk = 1'b0;
            if (scramble) buttons_pressed = ~pat;   // R9
            wait_n(HALF);
            chk(scramble ? "R9 R10 low phase" : "R10 low phase", ser_data, slot_bit(pat, s));
            host_clk = 1'b1;
            wait_n(2);
            chk("R11 sync delay", ser_data, slot_bit(pat, s));
            wait_n(2);
            chk("R3 advance", ser_data, (s + 1 < NS) ? slot_bit(pat, s + 1) : 1'b1);
            wait_n(HALF - 4);
        end
    endtask

    task automatic full_frame(input logic [NB-1:0] pat, input bit scramble);
        latch_frame(pat, "R2 slot0");
        clock_slots(pat, NS, scramble);
        chk("R7 after frame", ser_data, 1'b1);
        for (int k = 0; k < 3; k++) begin
            host_clk = 1'b0; wait_n(HALF);
            chk("R7 extra low", ser_data, 1'b1);
            host_clk = 1'b1; wait_n(HALF);
            chk("R7 extra high", ser_data, 1'b1);
        end
    endtask

    initial begin
        wait_n(3);
        chk("R1 in reset", ser_data, 1'b1);
        rst_n = 1'b1;
        wait_n(4);
        chk("R1 after reset", ser_data, 1'b1);
        // clock pulses before any latch leave the line released
        host_clk = 1'b0; wait_n(HALF);
        host_clk = 1'b1; wait_n(HALF);
        chk("R1 idle clock", ser_data, 1'b1);

        full_frame(12'h000, 1'b0);
        full_frame(12'hFFF, 1'b0);
        full_frame(12'hA5C, 1'b0);
        full_frame(12'h001, 1'b0);
        full_frame(12'h800, 1'b0);
        full_frame(12'h3C6, 1'b1);

        // R8: restart in mid-frame
        latch_frame(12'h0F0, "R2 slot0");
        clock_slots(12'h0F0, 5, 1'b0);
        latch_frame(12'h90A, "R8 restart slot0");
        clock_slots(12'h90A, NS, 1'b0);
        chk("R8 R7 end of restarted frame", ser_data, 1'b1);

        // R8: restart from a finished frame
        full_frame(12'h555, 1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule